// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Scheduler

This block keeps a single-data-rate SDRAM refreshed on behalf of the command sequencer that owns the memory bus. A free-running interval timer adds one owed refresh every `INTERVAL` cycles. The default of 781 cycles at 10 ns gives 8192 refreshes in 64 ms. Owed refreshes build up in a bounded debt counter while the sequencer is busy. Whenever something is owed, the block raises a bus request. Once the sequencer grants the bus, the block precharges all banks if any row is open, issues an AUTO REFRESH, and keeps the bus for the row-cycle time. If more refreshes are owed, it issues them back to back, one row-cycle apart.

The same ownership path carries self-refresh. While the self-refresh request is held, the block issues the entry command with CKE low and keeps CKE low. When the request is withdrawn, CKE rises and the block holds the bus for a guard window that carries only NOP cycles. After that window it hands the bus back. The interval timer restarts after self-refresh, because the device refreshed itself while it slept. When the debt reaches its limit, an urgent flag asks the sequencer to give refresh priority over normal traffic.

Top module: `sdram_refresh_sched`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `cmd_o` is 00 (NOP), `cke_o` is 1, `bus_req_o` is 0 and `urgent_o` is 0.
- R2: Outside self-refresh, one refresh becomes owed every `INTERVAL` cycles. With the bus never granted, `bus_req_o` first rises exactly `INTERVAL` cycles after reset release.
- R3: The block leaves its idle state only at a clock edge where both `bus_req_o` and `bus_grant` are high. Whenever `bus_req_o` is low, `cmd_o` is 00 and `cke_o` is 1. While a request waits without a grant, `cmd_o` stays 00.
- R4: If `banks_idle` is low at the granting edge, the next cycle carries `cmd_o` = 01 (precharge all), followed by `PRE_WAIT` NOP cycles, and then the refresh or self-refresh entry command. If `banks_idle` is high, `cmd_o` = 10 (auto refresh) appears in the cycle right after the granting edge.
- R5: Two `cmd_o` = 10 commands are always at least `TRC` cycles apart. After a refresh, `bus_req_o` stays high and `cmd_o` stays 00 for the `TRC`-1 cycles that follow it.
- R6: While refreshes remain owed and self-refresh is not requested, refreshes follow one another exactly every `TRC` cycles without the bus being released.
- R7: Up to `MAX_DEBT` refreshes can be owed. `urgent_o` is high exactly when `MAX_DEBT` are owed, and further interval expiries do not raise the count past that limit.
- R8: Self-refresh entry is `cmd_o` = 11 with `cke_o` = 0 in the same cycle. `cke_o` stays 0, with `cmd_o` 00 and `bus_req_o` high, for as long as `selfref_req` stays high. Entry clears all owed refreshes.
- R9: In the cycle after `selfref_req` is seen low during self-refresh, `cke_o` returns to 1. For `TXSR` cycles from then on, `cmd_o` is 00 and `bus_req_o` is high. The bus is released in the next cycle if nothing is owed.
- R10: The interval timer restarts at self-refresh exit. The next refresh is owed `INTERVAL` cycles after the first cycle with `cke_o` high again.
- R11: At the end of a refresh gap, a held `selfref_req` takes priority over owed refreshes. The next command is then 11, issued `TRC` cycles after the last refresh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Active-low synchronous reset |
| selfref_req | input | 1 | Level request to enter and stay in self-refresh |
| banks_idle | input | 1 | High when every bank is precharged |
| bus_grant | input | 1 | Sequencer hands the command bus to this block |
| bus_req_o | output | 1 | Block asks for or holds the command bus |
| urgent_o | output | 1 | Refresh debt at its limit; sequencer must yield |
| cmd_o | output | 2 | 00 NOP, 01 precharge all, 10 auto refresh, 11 self-refresh entry |
| cke_o | output | 1 | Clock enable to the SDRAM |

## Verification
The hardest situation to reach from the ports is a held self-refresh request arriving at the end of a refresh gap while other refreshes are still owed. Only then does the priority between the two kinds of work show. The bench first lets several intervals expire with the grant held low, so that debt builds up. It then grants the bus, issues one refresh, and raises the self-refresh request inside the gap. The same build-up, taken to the limit, also drives the debt into saturation. Granting with `banks_idle` low then brings out the full precharge path and a long run of back-to-back refreshes.

// File: rtl/sref_pkg.sv
package sref_pkg;

   typedef enum logic [1:0] {
      CMD_NOP    = 2'b00,
      CMD_PREALL = 2'b01,
      CMD_AREF   = 2'b10,
      CMD_SREF   = 2'b11
   } sref_cmd_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRECH,
      ST_TRP,
      ST_ISSUE,
      ST_GAP,
      ST_SELF,
      ST_EXIT
   } sref_state_e;

endpackage

// File: rtl/sref_interval_debt.sv
module sref_interval_debt #(
   parameter int INTERVAL = 781,
   parameter int MAX_DEBT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic consume_i,
   output logic pending_o,
   output logic urgent_o
);
   localparam int CW = $clog2(INTERVAL);
   localparam int DW = $clog2(MAX_DEBT + 1);
   localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);
   localparam logic [DW-1:0] TOP  = DW'(MAX_DEBT);

   logic [CW-1:0] cnt;
   logic [DW-1:0] debt;
   logic          tick;

   assign tick = !clr_i && (cnt == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         debt <= '0;
      end else if (clr_i) begin
         cnt  <= '0;
         debt <= '0;
      end else begin
         cnt <= tick ? '0 : cnt + 1'b1;
         if (tick && !consume_i && debt != TOP)
            debt <= debt + 1'b1;
         else if (consume_i && !tick && debt != '0)
            debt <= debt - 1'b1;
      end
   end

   assign pending_o = (debt != '0);
   assign urgent_o  = (debt == TOP);

endmodule

// File: rtl/sref_down_timer.sv
module sref_down_timer #(
   parameter int W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] val_i,
   output logic         done_o
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (load_i)
         cnt <= val_i;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign done_o = (cnt == '0);

endmodule

// File: rtl/sref_ctrl_fsm.sv
module sref_ctrl_fsm
   import sref_pkg::*;
#(
   parameter int TW       = 3,
   parameter int PRE_WAIT = 2,
   parameter int TRC      = 7,
   parameter int TXSR     = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sr_req_i,
   input  logic          banks_idle_i,
   input  logic          grant_i,
   input  logic          pending_i,
   input  logic          timer_done_i,
   output logic          timer_load_o,
   output logic [TW-1:0] timer_val_o,
   output logic          consume_o,
   output logic          sr_active_o,
   output logic [1:0]    cmd_o,
   output logic          cke_o,
   output logic          bus_req_o
);
   sref_state_e st, st_d;
   logic        sr_kind, kind_d;
   logic        work;
   sref_cmd_e   cmd;

   assign work = sr_req_i || pending_i;

   always_comb begin
      st_d         = st;
      kind_d       = sr_kind;
      timer_load_o = 1'b0;
      timer_val_o  = '0;
      unique case (st)
         ST_IDLE: if (work && grant_i) begin
            kind_d = sr_req_i;
            st_d   = banks_idle_i ? ST_ISSUE : ST_PRECH;
         end
         ST_PRECH: begin
            st_d         = ST_TRP;
            timer_load_o = 1'b1;
            timer_val_o  = TW'(PRE_WAIT - 1);
         end
         ST_TRP: if (timer_done_i) st_d = ST_ISSUE;
         ST_ISSUE: begin
            if (sr_kind) begin
               st_d = ST_SELF;
            end else begin
               st_d         = ST_GAP;
               timer_load_o = 1'b1;
               timer_val_o  = TW'(TRC - 2);
            end
         end
         ST_GAP: if (timer_done_i) begin
            if (sr_req_i) begin
               kind_d = 1'b1;
               st_d   = ST_ISSUE;
            end else if (pending_i) begin
               kind_d = 1'b0;
               st_d   = ST_ISSUE;
            end else begin
               st_d = ST_IDLE;
            end
         end
         ST_SELF: if (!sr_req_i) begin
            st_d         = ST_EXIT;
            timer_load_o = 1'b1;
            timer_val_o  = TW'(TXSR - 1);
         end
         ST_EXIT: if (timer_done_i) st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         sr_kind <= 1'b0;
      end else begin
         st      <= st_d;
         sr_kind <= kind_d;
      end
   end

   always_comb begin
      unique case (st)
         ST_PRECH: cmd = CMD_PREALL;
         ST_ISSUE: cmd = sr_kind ? CMD_SREF : CMD_AREF;
         default:  cmd = CMD_NOP;
      endcase
   end

   assign cmd_o       = cmd;
   assign sr_active_o = (st == ST_SELF) || (st == ST_ISSUE && sr_kind);
   assign cke_o       = !sr_active_o;
   assign consume_o   = (st == ST_ISSUE) && !sr_kind;
   assign bus_req_o   = (st != ST_IDLE) || work;

endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched
   import sref_pkg::*;
#(
   parameter int INTERVAL = 781,
   parameter int MAX_DEBT = 8,
   parameter int PRE_WAIT = 2,
   parameter int TRC      = 7,
   parameter int TXSR     = 7
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       selfref_req,
   input  logic       banks_idle,
   input  logic       bus_grant,
   output logic       bus_req_o,
   output logic       urgent_o,
   output logic [1:0] cmd_o,
   output logic       cke_o
);
   localparam int TMAX_A = (PRE_WAIT > TRC) ? PRE_WAIT : TRC;
   localparam int TMAX   = (TMAX_A > TXSR) ? TMAX_A : TXSR;
   localparam int TW     = $clog2(TMAX + 1);

   generate
      if (INTERVAL < 2) begin : g_bad_interval
         $error("INTERVAL must be at least 2");
      end
      if (MAX_DEBT < 1) begin : g_bad_debt
         $error("MAX_DEBT must be at least 1");
      end
      if (PRE_WAIT < 1) begin : g_bad_prewait
         $error("PRE_WAIT must be at least 1");
      end
      if (TRC < 2) begin : g_bad_trc
         $error("TRC must be at least 2");
      end
      if (TXSR < 1) begin : g_bad_txsr
         $error("TXSR must be at least 1");
      end
   endgenerate

   logic          pending;
   logic          consume;
   logic          sr_active;
   logic          timer_load;
   logic [TW-1:0] timer_val;
   logic          timer_done;

   sref_interval_debt #(
      .INTERVAL (INTERVAL),
      .MAX_DEBT (MAX_DEBT)
   ) debt_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (sr_active),
      .consume_i (consume),
      .pending_o (pending),
      .urgent_o  (urgent_o)
   );

   sref_down_timer #(
      .W (TW)
   ) timer_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (timer_load),
      .val_i  (timer_val),
      .done_o (timer_done)
   );

   sref_ctrl_fsm #(
      .TW       (TW),
      .PRE_WAIT (PRE_WAIT),
      .TRC      (TRC),
      .TXSR     (TXSR)
   ) fsm_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .sr_req_i     (selfref_req),
      .banks_idle_i (banks_idle),
      .grant_i      (bus_grant),
      .pending_i    (pending),
      .timer_done_i (timer_done),
      .timer_load_o (timer_load),
      .timer_val_o  (timer_val),
      .consume_o    (consume),
      .sr_active_o  (sr_active),
      .cmd_o        (cmd_o),
      .cke_o        (cke_o),
      .bus_req_o    (bus_req_o)
   );

endmodule

// File: rtl/sdram_refresh_sched_chk.sv
module sdram_refresh_sched_chk
   import sref_pkg::*;
#(
   parameter int TRC  = 7,
   parameter int TXSR = 7
) (
   input logic       clk,
   input logic       rst_n,
   input logic       bus_req_o,
   input logic       urgent_o,
   input logic [1:0] cmd_o,
   input logic       cke_o
);
   localparam int SW = $clog2(TRC + 1) + 1;
   localparam int XW = $clog2(TXSR + 1) + 1;
   localparam logic [SW-1:0] TRC_V  = SW'(TRC);
   localparam logic [XW-1:0] TXSR_V = XW'(TXSR);

   logic [SW-1:0] since_ref;
   logic [XW-1:0] since_wake;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since_ref  <= TRC_V;
         since_wake <= TXSR_V;
      end else begin
         if (cmd_o == CMD_AREF)      since_ref <= SW'(1);
         else if (since_ref < TRC_V) since_ref <= since_ref + 1'b1;
         if (!cke_o)                   since_wake <= '0;
         else if (since_wake < TXSR_V) since_wake <= since_wake + 1'b1;
      end
   end

   // R5
   aref_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == CMD_AREF) |-> (since_ref >= TRC_V));

   // R9
   wake_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cke_o && since_wake < TXSR_V) |-> (cmd_o == CMD_NOP && bus_req_o));

   // R8
   sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cke_o |-> ((cmd_o == CMD_NOP || cmd_o == CMD_SREF) && bus_req_o));

   // R8
   sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cke_o) |-> (cmd_o == CMD_SREF));

   // R3
   no_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_req_o |-> (cmd_o == CMD_NOP && cke_o));

   // R7
   urgent_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      urgent_o |-> bus_req_o);

   // R4
   prech_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == CMD_PREALL) |=> (cmd_o == CMD_NOP));

endmodule

bind sdram_refresh_sched sdram_refresh_sched_chk #(
   .TRC  (TRC),
   .TXSR (TXSR)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_req_o (bus_req_o),
   .urgent_o  (urgent_o),
   .cmd_o     (cmd_o),
   .cke_o     (cke_o)
);

// File: tb/sdram_refresh_sched_tb.sv
module sdram_refresh_sched_tb_top;
   localparam int INTV = 20;
   localparam int MAXD = 8;
   localparam int PW   = 2;
   localparam int TRC  = 7;
   localparam int TXSR = 7;

   localparam int E_NOP = 0, E_PRE = 1, E_REF = 2, E_SRE = 3, E_GAPEND = 4, E_EXIT = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sr_req = 1'b0;
   logic       banks = 1'b1;
   logic       grant = 1'b0;
   logic       bus_req, urgent, cke;
   logic [1:0] cmd;

   int    checks = 0;
   int    errors = 0;
   int    cyc = 0;
   int    last_ref = -1;
   bit    finished = 1'b0;
   string phase = "R1";

   // reference model state
   int m_cnt = 0;
   int m_debt = 0;
   bit m_self = 1'b0;
   int q[$];

   always #10 clk = ~clk;

   sdram_refresh_sched #(
      .INTERVAL (INTV),
      .MAX_DEBT (MAXD),
      .PRE_WAIT (PW),
      .TRC      (TRC),
      .TXSR     (TXSR)
   ) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .selfref_req (sr_req),
      .banks_idle  (banks),
      .bus_grant   (grant),
      .bus_req_o   (bus_req),
      .urgent_o    (urgent),
      .cmd_o       (cmd),
      .cke_o       (cke)
   );

   task automatic chk(input string tag, input bit ok, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s at cycle %0d: got %0d expected %0d", tag, cyc, act, exp);
      end
   endtask

   task automatic push_ref();
      q.push_back(E_REF);
      for (int i = 0; i < TRC - 2; i++) q.push_back(E_NOP);
      q.push_back(E_GAPEND);
   endtask

   function automatic int exp_cmd();
      if (q.size() == 0) return 0;
      case (q[0])
         E_PRE:   return 1;
         E_REF:   return 2;
         E_SRE:   return 3;
         default: return 0;
      endcase
   endfunction

   function automatic int exp_cke();
      if (q.size() != 0) return (q[0] == E_SRE) ? 0 : 1;
      return m_self ? 0 : 1;
   endfunction

   function automatic int exp_req();
      return (q.size() != 0 || m_self || sr_req || m_debt > 0) ? 1 : 0;
   endfunction

   // model advance at each clock edge
   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_debt = 0; m_self = 1'b0; q.delete();
      end else begin
         int  old_debt;
         bit  sr_act, tick, use_ref;
         old_debt = m_debt;
         sr_act   = (q.size() != 0 && q[0] == E_SRE) || (q.size() == 0 && m_self);
         tick     = !sr_act && (m_cnt == INTV - 1);
         use_ref  = (q.size() != 0 && q[0] == E_REF);
         if (q.size() != 0) begin
            int e;
            e = q.pop_front();
            if (e == E_SRE) m_self = 1'b1;
            else if (e == E_GAPEND) begin
               if (sr_req) q.push_back(E_SRE);
               else if (old_debt > 0) push_ref();
            end
         end else if (m_self) begin
            if (!sr_req) begin
               m_self = 1'b0;
               for (int i = 0; i < TXSR; i++) q.push_back(E_EXIT);
            end
         end else if ((sr_req || old_debt > 0) && grant) begin
            if (!banks) begin
               q.push_back(E_PRE);
               for (int i = 0; i < PW; i++) q.push_back(E_NOP);
            end
            if (sr_req) q.push_back(E_SRE);
            else push_ref();
         end
         if (sr_act) begin
            m_cnt = 0; m_debt = 0;
         end else begin
            m_cnt = (m_cnt == INTV - 1) ? 0 : m_cnt + 1;
            if (tick && !use_ref && m_debt < MAXD) m_debt++;
            else if (use_ref && !tick && m_debt > 0) m_debt--;
         end
      end
   end

   // per-cycle comparison against the model, and refresh spacing (R5)
   always @(negedge clk) begin
      cyc++;
      if (rst_n && !finished) begin
         chk({phase, " cmd_o"}, int'(cmd) == exp_cmd(), int'(cmd), exp_cmd());
         chk({phase, " cke_o"}, int'(cke) == exp_cke(), int'(cke), exp_cke());
         chk({phase, " bus_req_o"}, int'(bus_req) == exp_req(), int'(bus_req), exp_req());
         chk({phase, " urgent_o"}, int'(urgent) == ((m_debt == MAXD) ? 1 : 0), int'(urgent),
             (m_debt == MAXD) ? 1 : 0);
         if (cmd == 2'b10) begin
            if (last_ref >= 0) chk("R5 refresh spacing", (cyc - last_ref) >= TRC, cyc - last_ref, TRC);
            last_ref = cyc;
         end
      end
   end

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   task automatic finish_run();
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, got 0 expected 1");
         finish_run();
      end
   end

   initial begin
      int n, t0, a;
      repeat (3) step();
      chk("R1 cmd in reset", cmd == 2'b00, int'(cmd), 0);
      chk("R1 cke in reset", cke == 1'b1, int'(cke), 1);
      rst_n = 1'b1;
      t0 = cyc;
      chk("R1 bus_req after release", bus_req == 1'b0, int'(bus_req), 0);
      chk("R1 urgent after release", urgent == 1'b0, int'(urgent), 0);

      // R2: first owed refresh after one interval
      phase = "R2";
      n = 0;
      while (!bus_req && n < 1000) begin step(); n++; end
      chk("R2 first request delay", n == INTV, n, INTV);

      // R3: request waits without grant, bus stays quiet
      phase = "R3";
      for (int i = 0; i < 5; i++) begin
         step();
         chk("R3 quiet while not granted", cmd == 2'b00 && cke, int'(cmd), 0);
      end

      // R7: debt builds to the limit and saturates
      phase = "R7";
      while (!urgent && cyc - t0 < 1000) step();
      chk("R7 urgent at limit", (cyc - t0) == MAXD * INTV, cyc - t0, MAXD * INTV);
      repeat (2 * INTV) step();
      chk("R7 urgent held after extra expiries", urgent == 1'b1, int'(urgent), 1);

      // R4: precharge path
      phase = "R4";
      banks = 1'b0;
      grant = 1'b1;
      step();
      chk("R4 precharge all first", cmd == 2'b01, int'(cmd), 1);
      banks = 1'b1;
      step();
      chk("R4 wait nop 1", cmd == 2'b00, int'(cmd), 0);
      step();
      chk("R4 wait nop 2", cmd == 2'b00, int'(cmd), 0);
      step();
      chk("R4 refresh after wait", cmd == 2'b10, int'(cmd), 2);

      // R6: back-to-back refreshes
      phase = "R6";
      for (int k = 0; k < 3; k++) begin
         repeat (TRC) step();
         chk("R6 back-to-back refresh", cmd == 2'b10, int'(cmd), 2);
      end
      n = 0;
      while (bus_req && n < 2000) begin step(); n++; end
      chk("R6 debt drains", bus_req == 1'b0, int'(bus_req), 0);

      // R4 direct path, then R5 hold after refresh
      phase = "R4";
      n = 0;
      while (!bus_req && n < 1000) begin step(); n++; end
      step();
      chk("R4 direct refresh when banks idle", cmd == 2'b10, int'(cmd), 2);
      phase = "R5";
      for (int i = 0; i < TRC - 1; i++) begin
         step();
         chk("R5 bus held after refresh", bus_req == 1'b1 && cmd == 2'b00, int'(bus_req), 1);
      end
      step();
      chk("R5 bus released after gap", bus_req == 1'b0, int'(bus_req), 0);

      // R8: self-refresh entry through precharge
      phase = "R8";
      grant = 1'b0;
      sr_req = 1'b1;
      banks = 1'b0;
      step();
      chk("R8 request without grant stays quiet", bus_req == 1'b1 && cmd == 2'b00, int'(cmd), 0);
      grant = 1'b1;
      step();
      chk("R8 precharge before entry", cmd == 2'b01, int'(cmd), 1);
      banks = 1'b1;
      step();
      step();
      step();
      chk("R8 entry command", cmd == 2'b11, int'(cmd), 3);
      chk("R8 cke low at entry", cke == 1'b0, int'(cke), 0);
      grant = 1'b0;
      for (int i = 0; i < 5; i++) begin
         step();
         chk("R8 cke held low", cke == 1'b0 && cmd == 2'b00, int'(cke), 0);
      end
      chk("R8 debt cleared", urgent == 1'b0, int'(urgent), 0);

      // R9: guarded exit
      phase = "R9";
      sr_req = 1'b0;
      step();
      chk("R9 cke high after exit", cke == 1'b1, int'(cke), 1);
      chk("R9 first exit cycle nop", cmd == 2'b00, int'(cmd), 0);
      a = cyc;
      for (int i = 0; i < TXSR - 1; i++) begin
         step();
         chk("R9 guard window nop", cmd == 2'b00 && bus_req == 1'b1, int'(cmd), 0);
      end
      step();
      chk("R9 bus released after guard", bus_req == 1'b0, int'(bus_req), 0);

      // R10: interval restarts at exit
      phase = "R10";
      n = 0;
      while (!bus_req && n < 1000) begin step(); n++; end
      chk("R10 next request after restart", (cyc - a) == INTV, cyc - a, INTV);

      // R11: self-refresh request wins over owed refreshes at gap end
      phase = "R11";
      repeat (2 * INTV) step();
      grant = 1'b1;
      step();
      chk("R11 refresh issued first", cmd == 2'b10, int'(cmd), 2);
      step();
      sr_req = 1'b1;
      repeat (TRC - 1) step();
      chk("R11 entry takes priority", cmd == 2'b11 && cke == 1'b0, int'(cmd), 3);
      step();
      chk("R11 owed refreshes dropped", urgent == 1'b0 && cke == 1'b0, int'(cke), 0);
      sr_req = 1'b0;
      repeat (TXSR + 2) step();
      grant = 1'b0;
      repeat (3) step();
      finish_run();
   end

endmodule